// File: doc/BRIEF.md
# Clock-Policy Frame Replacement Selector

This block holds one use bit and one lock bit for each of a fixed number of memory frames and picks a victim frame when asked. It follows a second-chance rule with a circular pointer, the hand. A reference to a frame or a fill of a frame marks that frame as used. A replacement request starts a sweep from the hand. The sweep examines one frame per clock cycle. It gives a second chance to used frames by clearing their use bit and moving on. It passes over locked frames without touching them. It stops at the first unlocked frame whose use bit is 0.

The caller raises `req_i` for one cycle while `busy_o` is low. It then waits for either a one-cycle `done_o` pulse, with the chosen frame on `victim_o`, or a one-cycle `err_o` pulse when every frame examined in a full turn was locked. Page tables, transfers and translation are outside the block.

Top module: `clock_victim_sel`

## Requirements
- R1: An active-low asynchronous reset clears every use bit, every lock bit and the hand (to frame 0), and drives `busy_o`, `done_o` and `err_o` low.
- R2: A valid reference or a valid load sets the use bit of the indexed frame on the next edge. This happens even when the sweep clears that same frame in the same cycle, so the set takes priority over the clear.
- R3: The victim is the first frame, in increasing index order from the hand, whose lock bit is 0 and whose use bit is 0. The block presents it on `victim_o` together with a `done_o` pulse that lasts exactly one cycle.
- R4: Each unlocked frame that the sweep examines with its use bit at 1 has that bit cleared.
- R5: A locked frame is never chosen and its use bit is left unchanged. When lock set and lock clear hit the same frame in the same cycle, the frame ends locked.
- R6: After a victim is chosen, the hand points to the frame after the victim. Index N-1 wraps to 0.
- R7: If N frames in a row are examined and all of them are locked, the sweep ends with a one-cycle `err_o` pulse and no `done_o`. The hand is then back where the sweep began.
- R8: A request made while `busy_o` is high has no effect: no further sweep follows the current one.
- R9: A request is accepted on the edge at which it is seen while the block is idle, and `busy_o` is high from the next cycle. The sweep examines one frame per cycle. The outcome pulse is registered after k frames have been examined, so it appears k+1 cycles after the request cycle. During that outcome cycle `busy_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ref_valid_i | input | 1 | A frame is referenced this cycle |
| ref_idx_i | input | $clog2(NUM_FRAMES) | Index of the referenced frame |
| load_valid_i | input | 1 | A frame has just been filled |
| load_idx_i | input | $clog2(NUM_FRAMES) | Index of the filled frame |
| lock_set_i | input | NUM_FRAMES | Per-frame lock set mask; set wins over clear |
| lock_clr_i | input | NUM_FRAMES | Per-frame lock clear mask |
| req_i | input | 1 | Replacement request; honoured only while idle |
| busy_o | output | 1 | A sweep is in progress |
| done_o | output | 1 | One-cycle pulse: a victim was chosen |
| err_o | output | 1 | One-cycle pulse: a full turn found only locked frames |
| victim_o | output | $clog2(NUM_FRAMES) | Chosen frame; valid while done_o is high and held afterwards |

## Verification
A use bit that sticks or clears wrongly does not show at the ports until a later sweep. It then changes both the victim index and the sweep length, and the sweep length appears as the distance from the request to `done_o`. A wrong hand shows on the very next request, as a different victim and different latency. A lock bit in the wrong state either hands out a frame that must stay resident or turns a `done_o` into an `err_o`. The bench therefore compares the outcome, the victim and `busy_o` every cycle against a model of its own. Directed sweeps are chosen so that each fault moves the result by at least one cycle or one frame.

// File: rtl/clock_sel_pkg.sv
package clock_sel_pkg;
  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_SCAN = 1'b1
  } scan_state_e;
endpackage

// File: rtl/frame_bits.sv
module frame_bits #(
  parameter int unsigned NUM_FRAMES = 8,
  localparam int unsigned IDX_W = $clog2(NUM_FRAMES)
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  ref_valid_i,
  input  logic [IDX_W-1:0]      ref_idx_i,
  input  logic                  load_valid_i,
  input  logic [IDX_W-1:0]      load_idx_i,
  input  logic [NUM_FRAMES-1:0] lock_set_i,
  input  logic [NUM_FRAMES-1:0] lock_clr_i,
  input  logic                  clr_valid_i,
  input  logic [IDX_W-1:0]      clr_idx_i,
  output logic [NUM_FRAMES-1:0] use_o,
  output logic [NUM_FRAMES-1:0] lock_o
);

  for (genvar f = 0; f < NUM_FRAMES; f++) begin : g_frame
    logic use_bit, lock_bit, touch, wipe;

    // reference and load both mark the frame; either beats the sweep clear
    assign touch = (ref_valid_i  && (ref_idx_i  == IDX_W'(f))) ||
                   (load_valid_i && (load_idx_i == IDX_W'(f)));
    assign wipe  = clr_valid_i && (clr_idx_i == IDX_W'(f));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        use_bit  <= 1'b0;
        lock_bit <= 1'b0;
      end else begin
        if (touch)     use_bit <= 1'b1;
        else if (wipe) use_bit <= 1'b0;
        if (lock_set_i[f])      lock_bit <= 1'b1;
        else if (lock_clr_i[f]) lock_bit <= 1'b0;
      end
    end

    assign use_o[f]  = use_bit;
    assign lock_o[f] = lock_bit;
  end

endmodule

// File: rtl/clock_hand_fsm.sv
module clock_hand_fsm
  import clock_sel_pkg::*;
#(
  parameter int unsigned NUM_FRAMES = 8,
  localparam int unsigned IDX_W = $clog2(NUM_FRAMES)
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  req_i,
  input  logic [NUM_FRAMES-1:0] use_i,
  input  logic [NUM_FRAMES-1:0] lock_i,
  output logic                  clr_valid_o,
  output logic [IDX_W-1:0]      clr_idx_o,
  output logic [IDX_W-1:0]      hand_o,
  output logic                  busy_o,
  output logic                  done_o,
  output logic                  err_o,
  output logic [IDX_W-1:0]      victim_o
);

  localparam logic [IDX_W-1:0] SKIP_LAST = IDX_W'(NUM_FRAMES - 1);

  scan_state_e      state_q, state_d;
  logic [IDX_W-1:0] hand_q, hand_d;
  logic [IDX_W-1:0] skip_q, skip_d;   // consecutive locked frames seen
  logic [IDX_W-1:0] victim_q, victim_d;
  logic             done_q, done_d, err_q, err_d;
  logic             scanning, cur_lock, cur_use;

  assign scanning = (state_q == ST_SCAN);
  assign cur_lock = lock_i[hand_q];
  assign cur_use  = use_i[hand_q];

  assign clr_valid_o = scanning && !cur_lock && cur_use;
  assign clr_idx_o   = hand_q;

  always_comb begin
    state_d  = state_q;
    hand_d   = hand_q;
    skip_d   = skip_q;
    victim_d = victim_q;
    done_d   = 1'b0;
    err_d    = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (req_i) begin
          state_d = ST_SCAN;
          skip_d  = '0;
        end
      end
      ST_SCAN: begin
        hand_d = hand_q + IDX_W'(1);
        if (cur_lock) begin
          if (skip_q == SKIP_LAST) begin
            err_d   = 1'b1;
            state_d = ST_IDLE;
            skip_d  = '0;
          end else begin
            skip_d = skip_q + IDX_W'(1);
          end
        end else if (cur_use) begin
          skip_d = '0;
        end else begin
          done_d   = 1'b1;
          victim_d = hand_q;
          state_d  = ST_IDLE;
          skip_d   = '0;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      hand_q   <= '0;
      skip_q   <= '0;
      victim_q <= '0;
      done_q   <= 1'b0;
      err_q    <= 1'b0;
    end else begin
      state_q  <= state_d;
      hand_q   <= hand_d;
      skip_q   <= skip_d;
      victim_q <= victim_d;
      done_q   <= done_d;
      err_q    <= err_d;
    end
  end

  assign hand_o   = hand_q;
  assign busy_o   = scanning;
  assign done_o   = done_q;
  assign err_o    = err_q;
  assign victim_o = victim_q;

endmodule

// File: rtl/clock_victim_sel.sv
module clock_victim_sel #(
  parameter int unsigned NUM_FRAMES = 8,
  localparam int unsigned IDX_W = $clog2(NUM_FRAMES)
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  ref_valid_i,
  input  logic [IDX_W-1:0]      ref_idx_i,
  input  logic                  load_valid_i,
  input  logic [IDX_W-1:0]      load_idx_i,
  input  logic [NUM_FRAMES-1:0] lock_set_i,
  input  logic [NUM_FRAMES-1:0] lock_clr_i,
  input  logic                  req_i,
  output logic                  busy_o,
  output logic                  done_o,
  output logic                  err_o,
  output logic [IDX_W-1:0]      victim_o
);

  logic [NUM_FRAMES-1:0] use_q, lock_q;
  logic [IDX_W-1:0]      hand_q, clr_idx;
  logic                  clr_valid;

  frame_bits #(.NUM_FRAMES(NUM_FRAMES)) u_bits (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .ref_valid_i  (ref_valid_i),
    .ref_idx_i    (ref_idx_i),
    .load_valid_i (load_valid_i),
    .load_idx_i   (load_idx_i),
    .lock_set_i   (lock_set_i),
    .lock_clr_i   (lock_clr_i),
    .clr_valid_i  (clr_valid),
    .clr_idx_i    (clr_idx),
    .use_o        (use_q),
    .lock_o       (lock_q)
  );

  clock_hand_fsm #(.NUM_FRAMES(NUM_FRAMES)) u_hand (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .req_i       (req_i),
    .use_i       (use_q),
    .lock_i      (lock_q),
    .clr_valid_o (clr_valid),
    .clr_idx_o   (clr_idx),
    .hand_o      (hand_q),
    .busy_o      (busy_o),
    .done_o      (done_o),
    .err_o       (err_o),
    .victim_o    (victim_o)
  );

endmodule

// File: rtl/clock_victim_sel_chk.sv
module clock_victim_sel_chk #(
  parameter int unsigned NUM_FRAMES = 8,
  localparam int unsigned IDX_W = $clog2(NUM_FRAMES)
) (
  input logic                  clk_i,
  input logic                  rst_ni,
  input logic                  ref_valid_i,
  input logic [IDX_W-1:0]      ref_idx_i,
  input logic                  load_valid_i,
  input logic [IDX_W-1:0]      load_idx_i,
  input logic                  req_i,
  input logic                  busy_o,
  input logic                  done_o,
  input logic                  err_o,
  input logic [IDX_W-1:0]      victim_o,
  input logic [NUM_FRAMES-1:0] use_q,
  input logic [NUM_FRAMES-1:0] lock_q,
  input logic [IDX_W-1:0]      hand_q
);

  logic [NUM_FRAMES-1:0] use_prev, lock_prev;
  logic                  sweep_clears;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      use_prev  <= '0;
      lock_prev <= '0;
    end else begin
      use_prev  <= use_q;
      lock_prev <= lock_q;
    end
  end

  assign sweep_clears = busy_o && !lock_q[hand_q] && use_q[hand_q] &&
                        !(ref_valid_i && ref_idx_i == hand_q) &&
                        !(load_valid_i && load_idx_i == hand_q);

  // R1
  reset_idle_chk: assert property (@(posedge clk_i) $rose(rst_ni) |-> !busy_o && !done_o && !err_o);
  // R2
  ref_sets_use_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ref_valid_i |=> use_q[$past(ref_idx_i)]);
  // R3
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni) done_o |=> !done_o);
  // R3
  victim_unused_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !use_prev[victim_o]);
  // R4
  sweep_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sweep_clears |=> !use_q[$past(hand_q)]);
  // R5
  victim_unlocked_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !lock_prev[victim_o]);
  // R6
  hand_after_victim_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> hand_q == victim_o + IDX_W'(1));
  // R7
  outcome_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({busy_o, done_o, err_o}));
  // R9
  busy_from_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(req_i));

endmodule

bind clock_victim_sel clock_victim_sel_chk #(.NUM_FRAMES(NUM_FRAMES)) u_chk (
  .clk_i, .rst_ni, .ref_valid_i, .ref_idx_i, .load_valid_i, .load_idx_i,
  .req_i, .busy_o, .done_o, .err_o, .victim_o, .use_q, .lock_q, .hand_q
);

// File: tb/clock_victim_sel_tb_top.sv
module clock_victim_sel_tb_top;
  localparam int N  = 8;
  localparam int IW = $clog2(N);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req = 1'b0, ref_v = 1'b0, load_v = 1'b0;
  logic [IW-1:0] ref_idx = '0, load_idx = '0;
  logic [N-1:0]  lset = '0, lclr = '0;
  logic          busy, done, err;
  logic [IW-1:0] victim;

  int errors = 0;
  int checks = 0;
  bit model_on = 1'b0;

  always #5 clk = ~clk;

  clock_victim_sel #(.NUM_FRAMES(N)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .ref_valid_i(ref_v), .ref_idx_i(ref_idx),
    .load_valid_i(load_v), .load_idx_i(load_idx), .lock_set_i(lset),
    .lock_clr_i(lclr), .req_i(req), .busy_o(busy), .done_o(done),
    .err_o(err), .victim_o(victim)
  );

  // reference model, written from the requirements
  logic [N-1:0]  m_use, m_lock, u_nx;
  logic [IW-1:0] m_hand, m_skip, e_vic, h;
  logic          m_busy, e_done, e_err;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_use = '0; m_lock = '0; m_hand = '0; m_skip = '0;
      m_busy = 1'b0; e_done = 1'b0; e_err = 1'b0; e_vic = '0;
    end else begin
      e_done = 1'b0; e_err = 1'b0; u_nx = m_use;
      if (m_busy) begin
        h = m_hand;
        m_hand = h + 1'b1;
        if (m_lock[h]) begin
          if (m_skip == IW'(N-1)) begin e_err = 1'b1; m_busy = 1'b0; m_skip = '0; end
          else m_skip = m_skip + 1'b1;
        end else if (m_use[h]) begin
          u_nx[h] = 1'b0; m_skip = '0;
        end else begin
          e_done = 1'b1; e_vic = h; m_busy = 1'b0; m_skip = '0;
        end
      end else if (req) begin
        m_busy = 1'b1; m_skip = '0;
      end
      if (load_v) u_nx[load_idx] = 1'b1;
      if (ref_v)  u_nx[ref_idx]  = 1'b1;
      m_use  = u_nx;
      m_lock = (m_lock & ~lclr) | lset;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // per-cycle comparison against the model (R3, R7, R9)
  always @(negedge clk) begin
    if (model_on && rst_n) begin
      chk(busy == m_busy, "R9 busy", int'(busy), int'(m_busy));
      chk(done == e_done, "R3 done", int'(done), int'(e_done));
      chk(err == e_err,   "R7 err",  int'(err),  int'(e_err));
      if (e_done) chk(victim == e_vic, "R3 victim", int'(victim), int'(e_vic));
    end
  end

  task automatic fire_req(input int ref_frame, output int w, output bit got_err, output int vic);
    req = 1'b1;
    @(negedge clk);
    req = 1'b0;
    w = 1;
    if (ref_frame >= 0) begin ref_v = 1'b1; ref_idx = IW'(ref_frame); end
    @(negedge clk);
    ref_v = 1'b0;
    w = 2;
    while (!(done || err) && w < 4*N) begin
      @(negedge clk);
      w++;
    end
    got_err = err;
    vic = int'(victim);
  endtask

  task automatic load_all();
    for (int i = 0; i < N; i++) begin
      load_v = 1'b1; load_idx = IW'(i);
      @(negedge clk);
    end
    load_v = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int w, vic;
    bit ge;
    int quiet;
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(!busy && !done && !err, "R1 outputs low in reset", int'({busy, done, err}), 0);
    rst_n = 1'b1;
    model_on = 1'b1;
    @(negedge clk);
    chk(!busy && !done && !err, "R1 outputs low after reset", int'({busy, done, err}), 0);

    // R1/R6: hand starts at 0, all use clear -> victim 0 after one frame
    fire_req(-1, w, ge, vic);
    chk(vic == 0 && !ge, "R1 first victim", vic, 0);
    chk(w == 2, "R9 latency one frame", w, 2);

    // R4/R6: all used, hand=1 -> full clearing turn, wrap, victim 1
    load_all();
    fire_req(-1, w, ge, vic);
    chk(vic == 1, "R4 victim after clearing turn", vic, 1);
    chk(w == N + 2, "R6 wrap latency", w, N + 2);

    // R4: frame 2 used, frame 3 clear -> victim 3
    load_v = 1'b1; load_idx = IW'(2); @(negedge clk); load_v = 1'b0;
    fire_req(-1, w, ge, vic);
    chk(vic == 3 && w == 3, "R4 second chance", vic, 3);

    // R5: lock 4,5; hand=4 -> victim 6
    lset = 8'h30; @(negedge clk); lset = '0;
    fire_req(-1, w, ge, vic);
    chk(vic == 6 && w == 4, "R5 locked skipped", vic, 6);

    // R7: everything locked -> err after N frames
    lset = '1; @(negedge clk); lset = '0;
    fire_req(-1, w, ge, vic);
    chk(ge == 1'b1, "R7 error flagged", int'(ge), 1);
    chk(w == N + 1, "R7 full turn", w, N + 1);

    // R5: set wins over clear; only frame 0 ends unlocked; hand=7 -> victim 0
    lclr = '1; lset = 8'hFE; @(negedge clk); lclr = '0; lset = '0;
    fire_req(-1, w, ge, vic);
    chk(vic == 0 && w == 3, "R5 lock set beats clear", vic, 0);

    // R8: second request while busy is ignored
    lclr = '1; @(negedge clk); lclr = '0;
    load_all();
    req = 1'b1; @(negedge clk); req = 1'b0;
    @(negedge clk); @(negedge clk);
    req = 1'b1; @(negedge clk); req = 1'b0;
    w = 4;
    while (!done && w < 4*N) begin @(negedge clk); w++; end
    chk(int'(victim) == 1, "R8 victim of first sweep", int'(victim), 1);
    quiet = 0;
    for (int i = 0; i < N + 2; i++) begin
      @(negedge clk);
      if (busy || done) quiet++;
    end
    chk(quiet == 0, "R8 no second sweep", quiet, 0);

    // R2: reference on the frame being cleared keeps it used; hand=2
    load_all();
    fire_req(2, w, ge, vic);
    chk(vic == 3, "R2 reference beats clear", vic, 3);
    chk(w == N + 3, "R2 sweep length", w, N + 3);

    // random phase, checked by the per-cycle model
    for (int c = 0; c < 4000; c++) begin
      req    = ($urandom % 4) == 0;
      ref_v  = ($urandom % 2) == 0;
      ref_idx  = IW'($urandom);
      load_v = ($urandom % 4) == 0;
      load_idx = IW'($urandom);
      for (int b = 0; b < N; b++) begin
        lset[b] = ($urandom % 48) == 0;
        lclr[b] = ($urandom % 6) == 0;
      end
      @(negedge clk);
    end
    req = 1'b0; ref_v = 1'b0; load_v = 1'b0; lset = '0; lclr = '0;
    repeat (3*N) @(negedge clk);

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule